// File: doc/BRIEF.md
# Address-Translation Configuration Register File

This block is the software-visible register bank of an I/O address-translation unit. A host reads and writes it one 32-bit word at a time. The word index is the byte offset shifted right by two. Each register applies its own write mask, forces some bits high and has its own reset value. The mask-ID register only accumulates bits on a write and never clears them.

A write to the control register also decodes its 3-bit window-size field into the start address of the translation window. That window always ends at the top of the 32-bit address space. The block drives the page-table base, the window start and the enable bit straight to the translation engine.

The engine reports a faulting access through a one-cycle capture strobe. The block then builds the fault status word, latches the faulting address and raises the fault interrupt. Software lowers the interrupt by reading or writing either the fault status register or the fault address register.

Top module: `xcr_regfile`

## Requirements
- R1: After reset the registers hold these values: control = VERSION_ID in bits [31:24] with all other bits 0; fault status = 0x00800000; master arbiter enable = 0x00000003; slave arbitration = 0x00000008; mask-ID = 0x23000000; every other register = 0. The outputs are winStart = 0, xlatEnable = 0 and faultIrq = 0.
- R2: A write to the control register (word 0x000) stores data & 0x0000001D ORed with VERSION_ID in bits [31:24]. xlatEnable follows the stored bit 0.
- R3: A control write sets winStart to 0xFFFFFFFF shifted left by (24 + code), where code is written bits [4:2]. Code 0 gives 0xFF000000 and code 7 gives 0x80000000. winStart changes only on a control write.
- R4: The page-table base register (word 0x001) stores data & 0x07FFFC00. ptBase outputs the stored value.
- R5: The two flush registers (words 0x005 and 0x006) store all 32 written bits.
- R6: A fault status write (word 0x400) stores (data & 0xFF0FFFFF) | 0x00800000. A fault address write (word 0x401) stores the data unchanged.
- R7: The master arbiter enable register (word 0x402) stores (data & 0x801F000F) | 0x00000001.
- R8: Four slot configuration registers (words 0x404 to 0x407) each store data & 0x00010003, independently of one another.
- R9: The slave arbitration register (word 0x800) stores (data & 0x001F0000) | 0x00000008.
- R10: A mask-ID write (word 0xC06) ORs data & 0x00FFFFFF into the current value and never clears any bit.
- R11: Any word index not listed above reads as 0, and writes to it change no register.
- R12: A read (selStb=1, wrEn=0) returns its data with rdValid=1 on the cycle after the strobe. A write never raises rdValid.
- R13: A capture strobe sets fault status to 0xC0820000, or 0xC0860000 when faultIsRd=1, loads the fault address register with faultAddr and raises faultIrq.
- R14: Any read or write of word 0x400 or 0x401 lowers faultIrq on the next cycle. If a capture arrives in the same cycle, the capture wins and faultIrq stays high. A read in that same cycle returns the value the register held before the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selStb | input | 1 | Access strobe, one cycle per access |
| wrEn | input | 1 | 1 = write, 0 = read for the strobed access |
| wordIdx | input | 12 | Word index (byte offset >> 2) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after a read strobe |
| faultCapStb | input | 1 | Fault capture strobe from the translation engine |
| faultIsRd | input | 1 | The faulting access was a read |
| faultAddr | input | 32 | Faulting page address |
| ptBase | output | 32 | Page-table base register value |
| winStart | output | 32 | Start of the translation window |
| xlatEnable | output | 1 | Translation enable (control bit 0) |
| faultIrq | output | 1 | Fault interrupt |

## Verification
The assertions check the timing rules on every cycle:
- read latency, and rdValid staying low for writes (R12);
- the interrupt rising on a capture, holding while nothing clears it, and falling on a fault-register access (R13, R14);
- winStart staying stable and 16 MB-aligned between control writes (R3);
- the bits the page-table base keeps (R4).

Only the bench scenarios can show the rest: each register's mask and forced bits, the OR-accumulating mask-ID write, the four separate slot registers, the ignored unlisted offsets, and the content of the captured fault word.

// File: rtl/xcr_pkg.sv
package xcr_pkg;
  localparam int IDX_W = 12;
  localparam int DW = 32;

  localparam logic [IDX_W-1:0] IX_CTRL   = 12'h000;
  localparam logic [IDX_W-1:0] IX_PTB    = 12'h001;
  localparam logic [IDX_W-1:0] IX_TLBF   = 12'h005;
  localparam logic [IDX_W-1:0] IX_PGF    = 12'h006;
  localparam logic [IDX_W-1:0] IX_FSTAT  = 12'h400;
  localparam logic [IDX_W-1:0] IX_FADDR  = 12'h401;
  localparam logic [IDX_W-1:0] IX_MARB   = 12'h402;
  localparam logic [IDX_W-1:0] IX_SLOT0  = 12'h404;
  localparam logic [IDX_W-1:0] IX_SARB   = 12'h800;
  localparam logic [IDX_W-1:0] IX_MASKID = 12'hC06;

  localparam logic [DW-1:0] MK_CTRL  = 32'h0000_001D;
  localparam logic [DW-1:0] MK_PTB   = 32'h07FF_FC00;
  localparam logic [DW-1:0] MK_FSTAT = 32'hFF0F_FFFF;
  localparam logic [DW-1:0] ONE_FSTAT= 32'h0080_0000;
  localparam logic [DW-1:0] MK_MARB  = 32'h801F_000F;
  localparam logic [DW-1:0] RST_MARB = 32'h0000_0003;
  localparam logic [DW-1:0] MK_SLOT  = 32'h0001_0003;
  localparam logic [DW-1:0] MK_SARB  = 32'h001F_0000;
  localparam logic [DW-1:0] ONE_SARB = 32'h0000_0008;
  localparam logic [DW-1:0] MK_MID   = 32'h00FF_FFFF;
  localparam logic [DW-1:0] RST_MID  = 32'h2300_0000;
  // fault word: error summary, late error, forced bit, address valid; read flag
  localparam logic [DW-1:0] FLT_BASE = 32'hC082_0000;
  localparam logic [DW-1:0] FLT_RD   = 32'h0004_0000;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_PTB, RG_TLBF, RG_PGF, RG_FSTAT,
    RG_FADDR, RG_MARB, RG_SLOT, RG_SARB, RG_MID
  } regId_e;

  typedef struct packed {
    logic   wrStb;
    logic   rdStb;
    regId_e regSel;
    logic [3:0] slot;
    logic   irqClr;
  } accStrobes_t;
endpackage

// File: rtl/xcr_ctrl.sv
module xcr_ctrl
  import xcr_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic             selStb,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wordIdx,
  output accStrobes_t      acc
);
  localparam logic [IDX_W-1:0] SLOT_LAST = IX_SLOT0 + IDX_W'(NUM_SLOTS - 1);

  regId_e regSel;
  logic [IDX_W-1:0] slotOff;

  always_comb begin
    slotOff = wordIdx - IX_SLOT0;
    regSel  = RG_NONE;
    if (wordIdx >= IX_SLOT0 && wordIdx <= SLOT_LAST) regSel = RG_SLOT;
    else begin
      case (wordIdx)
        IX_CTRL:   regSel = RG_CTRL;
        IX_PTB:    regSel = RG_PTB;
        IX_TLBF:   regSel = RG_TLBF;
        IX_PGF:    regSel = RG_PGF;
        IX_FSTAT:  regSel = RG_FSTAT;
        IX_FADDR:  regSel = RG_FADDR;
        IX_MARB:   regSel = RG_MARB;
        IX_SARB:   regSel = RG_SARB;
        IX_MASKID: regSel = RG_MID;
        default:   regSel = RG_NONE;
      endcase
    end
  end

  always_comb begin
    acc.wrStb  = selStb && wrEn;
    acc.rdStb  = selStb && !wrEn;
    acc.regSel = regSel;
    acc.slot   = slotOff[3:0];
    acc.irqClr = selStb && (regSel == RG_FSTAT || regSel == RG_FADDR);
  end
endmodule

// File: rtl/xcr_datapath.sv
module xcr_datapath
  import xcr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter logic [7:0] VERSION_ID = 8'h43
) (
  input  logic          clk,
  input  logic          rstN,
  input  accStrobes_t   acc,
  input  logic [DW-1:0] wrData,
  input  logic          faultCapStb,
  input  logic          faultIsRd,
  input  logic [DW-1:0] faultAddr,
  output logic [DW-1:0] rdData,
  output logic          rdValid,
  output logic [DW-1:0] ptBase,
  output logic [DW-1:0] winStart,
  output logic          xlatEnable,
  output logic          faultIrq
);
  localparam logic [DW-1:0] VER_WORD = {VERSION_ID, 24'h0};

  logic [DW-1:0] ctrlQ, ptbQ, tlbfQ, pgfQ, fstatQ, faddrQ, marbQ, sarbQ, midQ;
  logic [DW-1:0] slotQ [NUM_SLOTS];
  logic [DW-1:0] winQ, rdMux;
  logic          irqQ;

  function automatic logic wrHit(accStrobes_t a, regId_e r);
    return a.wrStb && a.regSel == r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= VER_WORD;  ptbQ <= '0;  tlbfQ <= '0;  pgfQ <= '0;
      fstatQ <= ONE_FSTAT; faddrQ <= '0; marbQ <= RST_MARB;
      sarbQ <= ONE_SARB;  midQ <= RST_MID; winQ <= '0; irqQ <= 1'b0;
    end else begin
      if (wrHit(acc, RG_CTRL)) begin
        ctrlQ <= (wrData & MK_CTRL) | VER_WORD;
        winQ  <= 32'hFFFF_FFFF << (24 + int'(wrData[4:2]));
      end
      if (wrHit(acc, RG_PTB))  ptbQ  <= wrData & MK_PTB;
      if (wrHit(acc, RG_TLBF)) tlbfQ <= wrData;
      if (wrHit(acc, RG_PGF))  pgfQ  <= wrData;
      if (wrHit(acc, RG_MARB)) marbQ <= (wrData & MK_MARB) | 32'h1;
      if (wrHit(acc, RG_SARB)) sarbQ <= (wrData & MK_SARB) | ONE_SARB;
      if (wrHit(acc, RG_MID))  midQ  <= midQ | (wrData & MK_MID);
      // engine capture takes precedence over a software write
      if (faultCapStb) begin
        fstatQ <= FLT_BASE | (faultIsRd ? FLT_RD : '0);
        faddrQ <= faultAddr;
        irqQ   <= 1'b1;
      end else begin
        if (wrHit(acc, RG_FSTAT)) fstatQ <= (wrData & MK_FSTAT) | ONE_FSTAT;
        if (wrHit(acc, RG_FADDR)) faddrQ <= wrData;
        if (acc.irqClr) irqQ <= 1'b0;
      end
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) slotQ[s] <= '0;
      else if (wrHit(acc, RG_SLOT) && int'(acc.slot) == s) slotQ[s] <= wrData & MK_SLOT;
    end
  end

  always_comb begin
    case (acc.regSel)
      RG_CTRL:  rdMux = ctrlQ;
      RG_PTB:   rdMux = ptbQ;
      RG_TLBF:  rdMux = tlbfQ;
      RG_PGF:   rdMux = pgfQ;
      RG_FSTAT: rdMux = fstatQ;
      RG_FADDR: rdMux = faddrQ;
      RG_MARB:  rdMux = marbQ;
      RG_SLOT:  rdMux = slotQ[acc.slot[$clog2(NUM_SLOTS)-1:0]];
      RG_SARB:  rdMux = sarbQ;
      RG_MID:   rdMux = midQ;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0; rdValid <= 1'b0;
    end else begin
      rdValid <= acc.rdStb;
      if (acc.rdStb) rdData <= rdMux;
    end
  end

  assign ptBase     = ptbQ;
  assign winStart   = winQ;
  assign xlatEnable = ctrlQ[0];
  assign faultIrq   = irqQ;
endmodule

// File: rtl/xcr_regfile.sv
module xcr_regfile
  import xcr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter logic [7:0] VERSION_ID = 8'h43
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selStb,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic [DW-1:0]    wrData,
  output logic [DW-1:0]    rdData,
  output logic             rdValid,
  input  logic             faultCapStb,
  input  logic             faultIsRd,
  input  logic [DW-1:0]    faultAddr,
  output logic [DW-1:0]    ptBase,
  output logic [DW-1:0]    winStart,
  output logic             xlatEnable,
  output logic             faultIrq
);
  accStrobes_t acc;

  xcr_ctrl #(.NUM_SLOTS(NUM_SLOTS)) ctrl_i (
    .selStb(selStb), .wrEn(wrEn), .wordIdx(wordIdx), .acc(acc)
  );

  xcr_datapath #(.NUM_SLOTS(NUM_SLOTS), .VERSION_ID(VERSION_ID)) dp_i (
    .clk(clk), .rstN(rstN), .acc(acc), .wrData(wrData),
    .faultCapStb(faultCapStb), .faultIsRd(faultIsRd), .faultAddr(faultAddr),
    .rdData(rdData), .rdValid(rdValid), .ptBase(ptBase), .winStart(winStart),
    .xlatEnable(xlatEnable), .faultIrq(faultIrq)
  );
endmodule

// File: rtl/xcr_regfile_chk.sv
module xcr_regfile_chk
  import xcr_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             selStb,
  input logic             wrEn,
  input logic [IDX_W-1:0] wordIdx,
  input logic             rdValid,
  input logic             faultCapStb,
  input logic [DW-1:0]    ptBase,
  input logic [DW-1:0]    winStart,
  input logic             faultIrq
);
  logic fltAcc, ctrlWr;
  assign fltAcc = selStb && (wordIdx == IX_FSTAT || wordIdx == IX_FADDR);
  assign ctrlWr = selStb && wrEn && wordIdx == IX_CTRL;

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    selStb && !wrEn |=> rdValid); // R12
  AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (!rstN)
    !(selStb && !wrEn) |=> !rdValid); // R12
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    faultCapStb |=> faultIrq); // R13
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    fltAcc && !faultCapStb |=> !faultIrq); // R14
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    faultIrq && !fltAcc |=> faultIrq); // R14
  AST_WIN_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable(winStart)); // R3

  always @(negedge clk) begin
    if (rstN) begin
      AST_WIN_ALIGN: assert (winStart[23:0] == 24'h0); // R3
      AST_PTB_MASK: assert ((ptBase & ~MK_PTB) == '0); // R4
    end
  end
endmodule

bind xcr_regfile xcr_regfile_chk chk_i (
  .clk(clk), .rstN(rstN), .selStb(selStb), .wrEn(wrEn), .wordIdx(wordIdx),
  .rdValid(rdValid), .faultCapStb(faultCapStb), .ptBase(ptBase),
  .winStart(winStart), .faultIrq(faultIrq)
);

// File: tb/xcr_regfile_tb_top.sv
module xcr_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selStb = 1'b0, wrEn = 1'b0;
  logic [11:0] wordIdx = '0;
  logic [31:0] wrData = '0, rdData;
  logic        rdValid;
  logic        faultCapStb = 1'b0, faultIsRd = 1'b0;
  logic [31:0] faultAddr = '0, ptBase, winStart;
  logic        xlatEnable, faultIrq;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  localparam logic [31:0] VERW = 32'h4300_0000;

  always #4 clk = ~clk; // 125 MHz

  xcr_regfile dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] idx, logic [31:0] d);
    @(negedge clk); selStb = 1; wrEn = 1; wordIdx = idx; wrData = d;
    @(negedge clk); selStb = 0; wrEn = 0;
  endtask

  task automatic rd(logic [11:0] idx, logic [31:0] exp, string req);
    @(negedge clk); selStb = 1; wrEn = 0; wordIdx = idx;
    expQ.push_back(exp); tagQ.push_back(req);
    @(negedge clk); selStb = 0;
  endtask

  // monitor: compare each returned read with the queued expectation
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) chk("R12 unexpected rdValid", 32'h1, 32'h0);
      else chk(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset values
    chk("R1 winStart", winStart, 32'h0);
    chk("R1 irq", {31'h0, faultIrq}, 32'h0);
    chk("R1 enable", {31'h0, xlatEnable}, 32'h0);
    rd(12'h000, VERW, "R1 ctrl");
    rd(12'h400, 32'h0080_0000, "R1 fstat");
    rd(12'h402, 32'h0000_0003, "R1 marb");
    rd(12'h800, 32'h0000_0008, "R1 sarb");
    rd(12'hC06, 32'h2300_0000, "R1 maskid");
    rd(12'h001, 32'h0, "R1 ptb");
    // R2, R3 control and window
    wr(12'h000, 32'hFFFF_FFFF);
    chk("R3 code7", winStart, 32'h8000_0000);
    chk("R2 enable", {31'h0, xlatEnable}, 32'h1);
    rd(12'h000, VERW | 32'h1D, "R2 ctrl mask");
    wr(12'h000, 32'h0000_0000);
    chk("R3 code0", winStart, 32'hFF00_0000);
    chk("R2 enable off", {31'h0, xlatEnable}, 32'h0);
    wr(12'h000, 32'h0000_000C);
    chk("R3 code3", winStart, 32'hF800_0000);
    wr(12'h001, 32'hFFFF_FFFF);
    chk("R3 stable", winStart, 32'hF800_0000);
    // R4
    chk("R4 ptBase", ptBase, 32'h07FF_FC00);
    rd(12'h001, 32'h07FF_FC00, "R4 ptb read");
    // R5
    wr(12'h005, 32'hDEAD_BEEF); wr(12'h006, 32'h1234_5678);
    rd(12'h005, 32'hDEAD_BEEF, "R5 tlbf");
    rd(12'h006, 32'h1234_5678, "R5 pgf");
    // R6
    wr(12'h400, 32'h0000_0000);
    rd(12'h400, 32'h0080_0000, "R6 fstat forced");
    wr(12'h400, 32'hFFFF_FFFF);
    rd(12'h400, 32'hFF8F_FFFF, "R6 fstat mask");
    wr(12'h401, 32'hCAFE_0123);
    rd(12'h401, 32'hCAFE_0123, "R6 faddr");
    // R7
    wr(12'h402, 32'h0000_0000);
    rd(12'h402, 32'h0000_0001, "R7 marb forced");
    wr(12'h402, 32'hFFFF_FFFF);
    rd(12'h402, 32'h801F_000F, "R7 marb mask");
    // R8
    for (int s = 0; s < 4; s++) wr(12'h404 + 12'(s), 32'hFFFF_FFF0 | 32'(s));
    rd(12'h404, 32'h0001_0000, "R8 slot0");
    rd(12'h405, 32'h0001_0001, "R8 slot1");
    rd(12'h406, 32'h0001_0002, "R8 slot2");
    rd(12'h407, 32'h0001_0003, "R8 slot3");
    // R9
    wr(12'h800, 32'hFFFF_FFFF);
    rd(12'h800, 32'h001F_0008, "R9 sarb");
    // R10
    wr(12'hC06, 32'hFF00_0011);
    rd(12'hC06, 32'h2300_0011, "R10 maskid or");
    wr(12'hC06, 32'h0000_0100);
    rd(12'hC06, 32'h2300_0111, "R10 maskid keep");
    // R11
    wr(12'h002, 32'hFFFF_FFFF); wr(12'h3FF, 32'hFFFF_FFFF);
    rd(12'h002, 32'h0, "R11 unlisted 002");
    rd(12'h3FF, 32'h0, "R11 unlisted 3FF");
    rd(12'h408, 32'h0, "R11 past slots");
    rd(12'h000, VERW | 32'h0C, "R11 ctrl untouched");
    // R12 write gives no rdValid: monitor flags any spurious one
    wr(12'h005, 32'h0);
    @(negedge clk);
    chk("R12 no rdValid after write", {31'h0, rdValid}, 32'h0);
    // R13 capture
    @(negedge clk); faultCapStb = 1; faultIsRd = 1; faultAddr = 32'h8765_4000;
    @(negedge clk); faultCapStb = 0;
    chk("R13 irq raise", {31'h0, faultIrq}, 32'h1);
    rd(12'h401, 32'h8765_4000, "R13 faddr");
    chk("R14 irq cleared by faddr read", {31'h0, faultIrq}, 32'h0);
    @(negedge clk); faultCapStb = 1; faultIsRd = 0; faultAddr = 32'h0000_1000;
    @(negedge clk); faultCapStb = 0;
    rd(12'h400, 32'hC082_0000, "R13 fstat write fault");
    chk("R14 irq cleared by fstat read", {31'h0, faultIrq}, 32'h0);
    // R14 capture wins over simultaneous read
    @(negedge clk); faultCapStb = 1; faultIsRd = 1; faultAddr = 32'h5;
    selStb = 1; wrEn = 0; wordIdx = 12'h400;
    expQ.push_back(32'hC082_0000); tagQ.push_back("R14 read sees old");
    @(negedge clk); faultCapStb = 0; selStb = 0;
    chk("R14 capture wins", {31'h0, faultIrq}, 32'h1);
    rd(12'h400, 32'hC086_0000, "R13 fstat read fault");
    wr(12'h401, 32'h0);
    chk("R14 irq cleared by write", {31'h0, faultIrq}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R12 all reads returned", 32'(expQ.size()), 32'h0);
    finishRun();
  end
endmodule